// File: doc/BRIEF.md
# Paired-Channel DMA Control Register Front End

This block is the register slave that sits in front of a multi-channel DMA engine. The channels come in pairs, and each pair forms an instance: the even channel moves data from a device into memory (receive) and the odd channel moves data from memory to a device (transmit). A simple 32-bit register bus reads and writes the per-channel descriptor pointers, length fields, receive enable bits and receive row widths. The block turns selected writes into one-cycle start and stop strobes for each channel's descriptor walker.

The block also gathers the channels' completion pulses into a shared interrupt status word. Software clears a status bit by writing one to it. A mask register and a read-only masked view sit beside the status word, and a level interrupt line is high whenever the masked view is nonzero. A global address-mode bit selects 32-bit addressing for the walkers. Read data is combinational: it is valid in the same cycle as the read enable.

Top module: `dma_csr_front`

## Requirements
- R1: After reset every stored register reads zero, `irq` and `addr32Mode` are low, and no start or stop strobe is asserted.
- R2: Instance n occupies byte offsets n*0x40 up to n*0x40+0x3F. Receive channel 2n uses these offsets within the instance: pointer high at 0x00, pointer low at 0x04, transfer length at 0x0C, buffer length at 0x10 and row width at 0x30. Transmit channel 2n+1 uses base 0x18 within the instance, with pointer high at +0x00, pointer low at +0x04, buffer length at +0x0C and transfer length at +0x14. Each of these registers holds a full 32-bit value and reads back what was last written to it.
- R3: A write to a transmit channel's pointer-low register raises that channel's `chStart` bit in the next cycle, for exactly one cycle. A write to a receive channel's pointer-low register raises no strobe.
- R4: A write to the receive enable register (instance offset 0x14) stores bit 0 of the write data, which reads back as bit 0. Writing a 1 pulses that receive channel's `chStart` for one cycle in the next cycle. Writing a 0 pulses its `chStop` the same way.
- R5: A one-cycle `chDone[c]` pulse sets bit c of the status register at 0x080000 from the next cycle on. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R6: When a done pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The pending register at 0x080004 reads as status AND the enable register at 0x080008. `irq` is high exactly when pending is nonzero. Writes to the pending register have no effect.
- R8: Bit 0 of the address-mode register at 0x000034 drives `addr32Mode` and reads back as bit 0.
- R9: A read from an offset that is not mapped, including offsets inside an instance beyond `NUM_INST`, returns zero. A write to such an offset changes no register and raises no strobe.
- R10: `chDescAddr[c*64 +: 64]` is {pointer high, pointer low} of channel c, and `rxRowBytes[n*32 +: 32]` is the row width of instance n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational |
| chDone | input | 2*NUM_INST | Per-channel completion pulse |
| chStart | output | 2*NUM_INST | Per-channel start strobe |
| chStop | output | 2*NUM_INST | Per-channel stop strobe (receive channels only) |
| chDescAddr | output | 2*NUM_INST*64 | Per-channel 64-bit descriptor pointer |
| rxRowBytes | output | NUM_INST*32 | Per-instance receive row width |
| addr32Mode | output | 1 | 32-bit addressing select |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle. A done pulse always sets its status bit, even against a clear. A clear with no competing pulse empties the bit, and with neither event the bit holds its value. Transmit pointer-low writes and receive disable writes are always followed by their strobe, start and stop never coincide on one channel, the interrupt stays low while the mask is zero, and unmapped reads return zero.

The register readback across the instance stride, the transmit offset shift, the masked pending view under random masks and done patterns, and the proof that stray writes left stored values untouched can only be shown through the bench's sequences of writes and reads.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam logic [31:0] STAT_ADDR = 32'h0008_0000;
  localparam logic [31:0] PEND_ADDR = 32'h0008_0004;
  localparam logic [31:0] IEN_ADDR  = 32'h0008_0008;
  localparam logic [31:0] ACTL_ADDR = 32'h0000_0034;

  typedef enum logic [3:0] {
    K_NONE, K_DHI, K_DLO, K_XLEN, K_BLEN, K_RXEN, K_ROWB,
    K_ACTL, K_STAT, K_PEND, K_IEN
  } regKind_e;

  // decoded bus access handed from control to datapath
  typedef struct packed {
    logic        wr;
    logic        rd;
    regKind_e    kind;
    logic [7:0]  chan;
    logic [31:0] data;
  } csrAcc_t;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output csrAcc_t               acc,
  output logic [2*NUM_INST-1:0] chStart,
  output logic [2*NUM_INST-1:0] chStop
);
  localparam int NCH = 2 * NUM_INST;

  logic [31:0]    fullAddr;
  logic [31:0]    instIdx;
  logic [5:0]     off;
  logic           isTx;
  regKind_e       kind;
  logic [NCH-1:0] startNxt;
  logic [NCH-1:0] stopNxt;

  // address decode
  always_comb begin
    fullAddr = 32'(busAddr);
    instIdx  = fullAddr >> 6;
    off      = fullAddr[5:0];
    isTx     = 1'b0;
    kind     = K_NONE;
    if (fullAddr == STAT_ADDR)      kind = K_STAT;
    else if (fullAddr == PEND_ADDR) kind = K_PEND;
    else if (fullAddr == IEN_ADDR)  kind = K_IEN;
    else if (fullAddr == ACTL_ADDR) kind = K_ACTL;
    else if (instIdx < 32'(NUM_INST)) begin
      case (off)
        6'h00: kind = K_DHI;
        6'h04: kind = K_DLO;
        6'h0C: kind = K_XLEN;
        6'h10: kind = K_BLEN;
        6'h14: kind = K_RXEN;
        6'h30: kind = K_ROWB;
        6'h18: begin kind = K_DHI;  isTx = 1'b1; end
        6'h1C: begin kind = K_DLO;  isTx = 1'b1; end
        6'h24: begin kind = K_BLEN; isTx = 1'b1; end
        6'h2C: begin kind = K_XLEN; isTx = 1'b1; end
        default: kind = K_NONE;
      endcase
    end
    acc.wr   = busWrEn;
    acc.rd   = busRdEn;
    acc.kind = kind;
    acc.chan = 8'(instIdx * 2 + 32'(isTx));
    acc.data = busWrData;
  end

  // strobe generation
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      startNxt[c] = 1'b0;
      stopNxt[c]  = 1'b0;
      if (acc.wr && acc.chan == 8'(c)) begin
        if (c % 2 == 1) begin
          startNxt[c] = (acc.kind == K_DLO);
        end else if (acc.kind == K_RXEN) begin
          startNxt[c] = acc.data[0];
          stopNxt[c]  = !acc.data[0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chStart <= '0;
      chStop  <= '0;
    end else begin
      chStart <= startNxt;
      chStop  <= stopNxt;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r4_start_stop_excl: assert property (@(posedge clk) disable iff (!rstN)
      !(chStart[c] && chStop[c]));
    if (c % 2 == 1) begin : g_tx
      a_r3_tx_start_follows: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && acc.kind == K_DLO && acc.chan == 8'(c)) |=> chStart[c]);
    end else begin : g_rx
      a_r4_rx_stop_follows: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && acc.kind == K_RXEN && acc.chan == 8'(c) && !busWrData[0])
          |=> chStop[c]);
    end
  end

endmodule

// File: rtl/dma_csr_dpath.sv
module dma_csr_dpath
  import dma_csr_pkg::*;
#(
  parameter int NUM_INST = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  csrAcc_t                  acc,
  input  logic [2*NUM_INST-1:0]    chDone,
  output logic [31:0]              busRdData,
  output logic [2*NUM_INST*64-1:0] chDescAddr,
  output logic [NUM_INST*32-1:0]   rxRowBytes,
  output logic                     addr32Mode,
  output logic                     irq
);
  localparam int NCH = 2 * NUM_INST;

  logic [31:0]    descHi [NCH];
  logic [31:0]    descLo [NCH];
  logic [31:0]    xferLen[NCH];
  logic [31:0]    bufLen [NCH];
  logic [31:0]    rowB   [NUM_INST];
  logic           rxEn   [NUM_INST];
  logic           actl;
  logic [NCH-1:0] stat;
  logic [NCH-1:0] ien;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] clrMask;

  assign clrMask = (acc.wr && acc.kind == K_STAT) ? acc.data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        descHi[c]  <= '0;
        descLo[c]  <= '0;
        xferLen[c] <= '0;
        bufLen[c]  <= '0;
      end
      for (int i = 0; i < NUM_INST; i++) begin
        rowB[i] <= '0;
        rxEn[i] <= 1'b0;
      end
      actl <= 1'b0;
      stat <= '0;
      ien  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (acc.wr && acc.chan == 8'(c)) begin
          case (acc.kind)
            K_DHI:   descHi[c]  <= acc.data;
            K_DLO:   descLo[c]  <= acc.data;
            K_XLEN:  xferLen[c] <= acc.data;
            K_BLEN:  bufLen[c]  <= acc.data;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NUM_INST; i++) begin
        if (acc.wr && acc.chan == 8'(2 * i)) begin
          if (acc.kind == K_RXEN) rxEn[i] <= acc.data[0];
          if (acc.kind == K_ROWB) rowB[i] <= acc.data;
        end
      end
      if (acc.wr && acc.kind == K_ACTL) actl <= acc.data[0];
      if (acc.wr && acc.kind == K_IEN)  ien  <= acc.data[NCH-1:0];
      // a done pulse wins over a same-cycle clear
      stat <= (stat & ~clrMask) | chDone;
    end
  end

  assign pend       = stat & ien;
  assign irq        = |pend;
  assign addr32Mode = actl;

  always_comb begin
    busRdData = '0;
    if (acc.rd) begin
      case (acc.kind)
        K_STAT: busRdData = 32'(stat);
        K_PEND: busRdData = 32'(pend);
        K_IEN:  busRdData = 32'(ien);
        K_ACTL: busRdData = {31'b0, actl};
        default: begin
          for (int c = 0; c < NCH; c++) begin
            if (acc.chan == 8'(c)) begin
              case (acc.kind)
                K_DHI:   busRdData = descHi[c];
                K_DLO:   busRdData = descLo[c];
                K_XLEN:  busRdData = xferLen[c];
                K_BLEN:  busRdData = bufLen[c];
                default: ;
              endcase
            end
          end
          for (int i = 0; i < NUM_INST; i++) begin
            if (acc.chan == 8'(2 * i)) begin
              if (acc.kind == K_RXEN) busRdData = {31'b0, rxEn[i]};
              if (acc.kind == K_ROWB) busRdData = rowB[i];
            end
          end
        end
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign chDescAddr[c*64 +: 64] = {descHi[c], descLo[c]};
  end
  for (genvar i = 0; i < NUM_INST; i++) begin : g_row
    assign rxRowBytes[i*32 +: 32] = rowB[i];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r6_done_sets: assert property (@(posedge clk) disable iff (!rstN)
      chDone[c] |=> stat[c]);
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
      (acc.wr && acc.kind == K_STAT && acc.data[c] && !chDone[c]) |=> !stat[c]);
    a_r5_stat_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!chDone[c] && !(acc.wr && acc.kind == K_STAT && acc.data[c]))
        |=> (stat[c] == $past(stat[c])));
  end

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ien == '0) |-> !irq);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (acc.rd && acc.kind == K_NONE) |-> (busRdData == 32'h0));

endmodule

// File: rtl/dma_csr_front.sv
module dma_csr_front
  import dma_csr_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWrData,
  output logic [31:0]              busRdData,
  input  logic [2*NUM_INST-1:0]    chDone,
  output logic [2*NUM_INST-1:0]    chStart,
  output logic [2*NUM_INST-1:0]    chStop,
  output logic [2*NUM_INST*64-1:0] chDescAddr,
  output logic [NUM_INST*32-1:0]   rxRowBytes,
  output logic                     addr32Mode,
  output logic                     irq
);
  csrAcc_t acc;

  dma_csr_ctrl #(.NUM_INST(NUM_INST), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .acc(acc),
    .chStart(chStart), .chStop(chStop)
  );

  dma_csr_dpath #(.NUM_INST(NUM_INST)) u_dpath (
    .clk(clk), .rstN(rstN), .acc(acc), .chDone(chDone),
    .busRdData(busRdData), .chDescAddr(chDescAddr), .rxRowBytes(rxRowBytes),
    .addr32Mode(addr32Mode), .irq(irq)
  );

endmodule

// File: tb/tb_dma_csr_front.sv
module tb_dma_csr_front;
  localparam int NI = 2;
  localparam int NC = 4;
  localparam int KH = 0, KL = 1, KX = 2, KB = 3, KE = 4, KR = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [19:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NC-1:0] chDone = '0;
  logic [NC-1:0] chStart, chStop;
  logic [NC*64-1:0] chDescAddr;
  logic [NI*32-1:0] rxRowBytes;
  logic addr32Mode, irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] mReg [NC][6];
  logic [NC-1:0] mStat = '0;
  logic [NC-1:0] mIen = '0;

  always #2 clk = ~clk;

  dma_csr_front #(.NUM_INST(NI), .ADDR_W(20)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .chDone(chDone), .chStart(chStart), .chStop(chStop),
    .chDescAddr(chDescAddr), .rxRowBytes(rxRowBytes),
    .addr32Mode(addr32Mode), .irq(irq)
  );

  function automatic logic [19:0] addrOf(int k, int ch);
    int base;
    int off;
    base = (ch / 2) * 'h40 + ((ch % 2 == 1) ? 'h18 : 0);
    off  = 0;
    case (k)
      KH: off = 'h00;
      KL: off = 'h04;
      KX: off = (ch % 2 == 1) ? 'h14 : 'h0C;
      KB: off = (ch % 2 == 1) ? 'h0C : 'h10;
      KE: off = 'h14;
      KR: off = 'h30;
      default: off = 0;
    endcase
    return 20'(base + off);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [19:0] a, logic [31:0] d, logic [NC-1:0] done);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; chDone = done;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; chDone = '0;
  endtask

  task automatic busRead(logic [19:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic pulseDone(logic [NC-1:0] m);
    @(negedge clk);
    chDone = m;
    @(posedge clk);
    @(negedge clk);
    chDone = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 6; k++) mReg[c][k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irq", 64'(irq), 0);
    chk("R1", "addr32Mode", 64'(addr32Mode), 0);
    chk("R1", "strobes", 64'({chStart, chStop}), 0);
    busRead(addrOf(KL, 3), v); chk("R1", "tx lo", 64'(v), 0);
    busRead(20'h80000, v);     chk("R1", "status", 64'(v), 0);

    // R2 / R10 random register traffic
    for (int n = 0; n < 60; n++) begin
      int ch;
      int k;
      logic [31:0] d;
      ch = $urandom_range(0, NC - 1);
      k  = (ch % 2 == 1) ? $urandom_range(0, 3) : $urandom_range(0, 4);
      if (k == KE) k = KR;
      d  = $urandom;
      busWrite(addrOf(k, ch), d, '0);
      mReg[ch][k] = d;
    end
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 4; k++) begin
        busRead(addrOf(k, c), v);
        chk("R2", $sformatf("ch%0d reg%0d", c, k), 64'(v), 64'(mReg[c][k]));
      end
      chk("R10", $sformatf("descAddr ch%0d", c), chDescAddr[c*64 +: 64],
          {mReg[c][KH], mReg[c][KL]});
    end
    for (int i = 0; i < NI; i++) begin
      busRead(addrOf(KR, 2 * i), v);
      chk("R2", "row width", 64'(v), 64'(mReg[2*i][KR]));
      chk("R10", "rxRowBytes", 64'(rxRowBytes[i*32 +: 32]), 64'(mReg[2*i][KR]));
    end

    // R3 transmit start strobe
    busWrite(addrOf(KL, 1), 32'h1000, '0);
    chk("R3", "tx start pulse", 64'(chStart), 64'(4'b0010));
    @(negedge clk);
    chk("R3", "tx start one cycle", 64'(chStart), 0);
    busWrite(addrOf(KL, 2), 32'h2000, '0);
    chk("R3", "rx lo no strobe", 64'({chStart, chStop}), 0);

    // R4 receive enable
    busWrite(addrOf(KE, 0), 32'h1, '0);
    chk("R4", "rx start", 64'({chStart, chStop}), 64'({4'b0001, 4'b0000}));
    busRead(addrOf(KE, 0), v);
    chk("R4", "enable readback", 64'(v), 1);
    busWrite(addrOf(KE, 0), 32'hFFFF_FFFE, '0);
    chk("R4", "rx stop", 64'({chStart, chStop}), 64'({4'b0000, 4'b0001}));
    busRead(addrOf(KE, 0), v);
    chk("R4", "enable cleared", 64'(v), 0);

    // R5 status set and clear
    pulseDone(4'b0100);
    busRead(20'h80000, v); chk("R5", "done sets", 64'(v), 64'(4'b0100));
    busWrite(20'h80000, 32'h0, '0);
    busRead(20'h80000, v); chk("R5", "write 0 keeps", 64'(v), 64'(4'b0100));
    busWrite(20'h80000, 32'h4, '0);
    busRead(20'h80000, v); chk("R5", "w1c", 64'(v), 0);

    // R6 set beats clear
    pulseDone(4'b0010);
    busWrite(20'h80000, 32'h2, 4'b0010);
    busRead(20'h80000, v); chk("R6", "set wins", 64'(v), 64'(4'b0010));
    busWrite(20'h80000, 32'hF, '0);
    busRead(20'h80000, v); chk("R6", "cleared after", 64'(v), 0);

    // R7 directed
    pulseDone(4'b0101);
    mStat = 4'b0101;
    chk("R7", "irq masked", 64'(irq), 0);
    busWrite(20'h80008, 32'h4, '0); mIen = 4'b0100;
    busRead(20'h80004, v); chk("R7", "pending", 64'(v), 64'(4'b0100));
    chk("R7", "irq on", 64'(irq), 1);
    busWrite(20'h80004, 32'h0, '0);
    busRead(20'h80004, v); chk("R7", "pending write ignored", 64'(v), 64'(4'b0100));
    busWrite(20'h80000, 32'h4, '0); mStat = 4'b0001;
    chk("R7", "irq off", 64'(irq), 0);

    // R7 random
    for (int n = 0; n < 30; n++) begin
      logic [NC-1:0] ie;
      logic [NC-1:0] dm;
      logic [NC-1:0] w1;
      ie = NC'($urandom_range(0, 15));
      dm = NC'($urandom_range(0, 15));
      w1 = NC'($urandom_range(0, 15));
      busWrite(20'h80008, 32'(ie), '0); mIen = ie;
      busWrite(20'h80000, 32'(w1), dm); mStat = (mStat & ~w1) | dm;
      busRead(20'h80004, v);
      chk("R7", "rand pending", 64'(v), 64'(mStat & mIen));
      chk("R7", "rand irq", 64'(irq), 64'(|(mStat & mIen)));
    end

    // R8 address mode
    busWrite(20'h00034, 32'h1, '0);
    chk("R8", "mode on", 64'(addr32Mode), 1);
    busRead(20'h00034, v); chk("R8", "mode readback", 64'(v), 1);

    // R9 unmapped
    busRead(20'h00008, v); chk("R9", "read gap", 64'(v), 0);
    busWrite(20'h00008, 32'hDEAD_BEEF, '0);
    chk("R9", "no strobe", 64'({chStart, chStop}), 0);
    busWrite(20'h00080, 32'h1234_5678, '0);
    busRead(20'h00080, v); chk("R9", "beyond instances", 64'(v), 0);
    busWrite(20'h00074, 32'h0, '0);
    chk("R9", "mode untouched", 64'(addr32Mode), 1);
    busRead(addrOf(KH, 0), v);
    chk("R9", "neighbour untouched", 64'(v), 64'(mReg[0][KH]));
    busWrite(20'h00034, 32'h0, '0);
    chk("R8", "mode off", 64'(addr32Mode), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule